// File: doc/BRIEF.md
# Interrupt Priority Encoder and Acknowledge Decoder

This block sits between seven active-low interrupt request lines and the three active-low priority-level inputs of a processor. It also handles the return path. The request lines first pass through a two-stage synchroniser. The highest-numbered pending request is then encoded into a 3-bit level code. The block drives that code inverted, so an all-high code means nothing is pending.

When the processor runs an interrupt-acknowledge bus cycle, the block recognises it from three signals:

- the function code is all ones;
- the upper address bits are all ones;
- the address strobe is low.

It then pulls low the one acknowledge line that belongs to the level carried on the three low address bits. The block also acts as the vectoring device for that level. On the next clock it drives the level's programmable 8-bit vector onto the low data byte. One clock after that it asserts the data acknowledge. Both are held until the strobe is released.

The processor's own mask comparison is outside this block. A level-7 request is encoded exactly like any other level.

Top module: `irq_glue`

## Requirements
- R1: After a synchronous reset, the outputs are idle: `ipl_n` = 3'b111, `vec_oe` = 0, `vec_out` = 0 and `dtack_n` = 1. The vector register of each level L (1..7) holds VEC_BASE + L, where VEC_BASE defaults to 8'h18.
- R2: Bit i of `req_n` is the request of level i+1 (0 = requesting). The requests are sampled by two flip-flops, so `ipl_n` follows a change on `req_n` two rising clock edges after the change.
- R3: The encoded level is the highest-numbered active synchronised request, or 0 when none is active. `ipl_n` is the bitwise inverse of that level, so no request gives 3'b111 and level 7 gives 3'b000.
- R4: An acknowledge cycle is recognised when all three of these hold: `as_n` = 0, `fc` = 3'b111, and `bus_addr[23:4]` is all ones. The serviced level is `bus_addr[3:1]`.
- R5: In a recognised acknowledge cycle for level L in 1..7, exactly bit L-1 of `iack_n` is 0, combinationally. For level 0, no bit is 0.
- R6: When `as_n` = 1, or `fc` is not 3'b111, or any bit of `bus_addr[23:4]` is 0, all `iack_n` bits are 1.
- R7: The first rising edge inside an acknowledge cycle for level 1..7 sets `vec_oe` = 1 and `vec_out` to that level's vector. Outside such a cycle, `vec_out` is 0.
- R8: `dtack_n` goes low on the rising edge after the one that set `vec_oe`. It stays low while the cycle lasts.
- R9: The first rising edge after the acknowledge cycle ends (strobe released) clears `vec_oe` to 0, sets `dtack_n` to 1 and sets `vec_out` to 0.
- R10: A rising edge with `cfg_we` = 1 and `cfg_lvl` in 1..7 loads `cfg_data` into that level's vector register. With `cfg_lvl` = 0 the write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 7 | Interrupt requests, active low; bit i is level i+1 |
| ipl_n | output | 3 | Encoded priority level, active low |
| as_n | input | 1 | Address strobe, active low |
| fc | input | 3 | Processor function code |
| bus_addr | input | 23 | Address bits 23..1 |
| iack_n | output | 7 | Per-level acknowledge, active low; bit i is level i+1 |
| vec_out | output | 8 | Vector for the low data byte |
| vec_oe | output | 1 | Drive enable for `vec_out` |
| dtack_n | output | 1 | Data transfer acknowledge, active low |
| cfg_we | input | 1 | Vector register write enable |
| cfg_lvl | input | 3 | Level whose vector is written |
| cfg_data | input | 8 | Vector value to write |

## Verification
Each result has a fixed latency from its stimulus:

- `iack_n` follows the bus inputs in the same cycle.
- `ipl_n` follows `req_n` two rising edges later.
- `vec_oe` and `vec_out` appear one edge into an acknowledge cycle.
- `dtack_n` appears two edges into the cycle.
- All handshake outputs release one edge after the strobe rises.

The bench drives inputs on the falling edge. It advances a behavioural model at each rising edge, with pipelines held as plain variables. It compares every output 2 ns after that edge, so each register stage is counted exactly once. Stimulus covers request patterns, all eight acknowledge levels, malformed acknowledge cycles, and vector writes that include the ignored level 0.

// File: rtl/irq_glue_pkg.sv
package irq_glue_pkg;

    localparam int NLVL   = 7;
    localparam int LVL_W  = 3;
    localparam int VEC_W  = 8;
    localparam int FC_W   = 3;
    localparam int ADDR_HI = 23;

    localparam logic [FC_W-1:0] FC_IACK = '1;

    typedef logic [LVL_W-1:0] level_t;
    typedef logic [VEC_W-1:0] vector_t;

    typedef struct packed {
        logic   hit;
        level_t lvl;
    } ack_t;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_DRIVE = 2'd1,
        HS_ACK   = 2'd2
    } hs_state_e;

    // highest set bit of act, as a level number 1..NLVL, 0 if none
    function automatic level_t top_level(input logic [NLVL-1:0] act);
        level_t l;
        l = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (act[i]) l = level_t'(i + 1);
        end
        return l;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_n,
    output logic [W-1:0] q_n
);
    logic [W-1:0] stage1, stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '1;
            stage2 <= '1;
        end else begin
            stage1 <= d_n;
            stage2 <= stage1;
        end
    end

    assign q_n = stage2;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_glue_pkg::*;
(
    input  logic [NLVL-1:0]  req_n,
    output logic [LVL_W-1:0] ipl_n
);
    level_t win;

    always_comb begin
        win   = top_level(~req_n);
        ipl_n = ~win;
    end
endmodule

// File: rtl/irq_ack_dec.sv
module irq_ack_dec
    import irq_glue_pkg::*;
(
    input  logic               as_n,
    input  logic [FC_W-1:0]    fc,
    input  logic [ADDR_HI:1]   bus_addr,
    output ack_t               ack,
    output logic [NLVL-1:0]    iack_n
);
    logic cyc;

    always_comb begin
        cyc     = !as_n && (fc == FC_IACK) && (&bus_addr[ADDR_HI:LVL_W+1]);
        ack.lvl = bus_addr[LVL_W:1];
        ack.hit = cyc && (bus_addr[LVL_W:1] != '0);
    end

    generate
        for (genvar g = 0; g < NLVL; g++) begin : g_ack
            assign iack_n[g] = !(ack.hit && (ack.lvl == level_t'(g + 1)));
        end
    endgenerate
endmodule

// File: rtl/irq_vec_regs.sv
module irq_vec_regs
    import irq_glue_pkg::*;
#(
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h18
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  level_t  wlvl,
    input  vector_t wdata,
    input  level_t  rlvl,
    output vector_t rdata
);
    vector_t regs [NLVL];

    generate
        for (genvar g = 0; g < NLVL; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    regs[g] <= VEC_BASE + vector_t'(g + 1);
                else if (we && wlvl == level_t'(g + 1))
                    regs[g] <= wdata;
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (rlvl == level_t'(i + 1)) rdata = regs[i];
        end
    end
endmodule

// File: rtl/irq_glue.sv
module irq_glue
    import irq_glue_pkg::*;
#(
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h18
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NLVL-1:0]    req_n,
    output logic [LVL_W-1:0]   ipl_n,
    input  logic               as_n,
    input  logic [FC_W-1:0]    fc,
    input  logic [ADDR_HI:1]   bus_addr,
    output logic [NLVL-1:0]    iack_n,
    output logic [VEC_W-1:0]   vec_out,
    output logic               vec_oe,
    output logic               dtack_n,
    input  logic               cfg_we,
    input  logic [LVL_W-1:0]   cfg_lvl,
    input  logic [VEC_W-1:0]   cfg_data
);
    logic [NLVL-1:0] req_s_n;
    ack_t            ack;
    vector_t         sel_vec;
    hs_state_e       hs;
    vector_t         vec_q;

    irq_sync #(.W(NLVL)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_n (req_n),
        .q_n (req_s_n)
    );

    irq_prio_enc u_enc (
        .req_n (req_s_n),
        .ipl_n (ipl_n)
    );

    // R3: idle code exactly when no synchronised request is active
    a_r3_idle_code: assert property (@(posedge clk) disable iff (rst)
        (&req_s_n) == (ipl_n == '1));
    // R3: a level-7 request always yields the top code
    a_r3_top_wins: assert property (@(posedge clk) disable iff (rst)
        !req_s_n[NLVL-1] |-> ipl_n == '0);

    irq_ack_dec u_dec (
        .as_n     (as_n),
        .fc       (fc),
        .bus_addr (bus_addr),
        .ack      (ack),
        .iack_n   (iack_n)
    );

    // R5: never more than one acknowledge line low
    a_r5_one_ack: assert property (@(posedge clk) disable iff (rst)
        $countones(~iack_n) <= 1);
    // R6: no acknowledge without the strobe
    a_r6_need_strobe: assert property (@(posedge clk) disable iff (rst)
        as_n |-> (&iack_n));

    irq_vec_regs #(.VEC_BASE(VEC_BASE)) u_vec (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wlvl  (cfg_lvl),
        .wdata (cfg_data),
        .rlvl  (ack.lvl),
        .rdata (sel_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hs    <= HS_IDLE;
            vec_q <= '0;
        end else begin
            vec_q <= ack.hit ? sel_vec : '0;
            if (!ack.hit)            hs <= HS_IDLE;
            else if (hs == HS_IDLE)  hs <= HS_DRIVE;
            else                     hs <= HS_ACK;
        end
    end

    assign vec_out = vec_q;
    assign vec_oe  = (hs != HS_IDLE);
    assign dtack_n = (hs != HS_ACK);

    // R7: vector is driven only after an acknowledge cycle was seen
    a_r7_drive_cause: assert property (@(posedge clk) disable iff (rst)
        vec_oe |-> $past(!as_n && fc == FC_IACK));
    // R8: data acknowledge only after the vector was already driven
    a_r8_dtack_after: assert property (@(posedge clk) disable iff (rst)
        !dtack_n |-> $past(vec_oe));
    // R9: strobe released means handshake dropped on the next edge
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        as_n |=> (!vec_oe && dtack_n));
endmodule

// File: tb/test_irq_glue.sv
module test_irq_glue;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  req_n = 7'h7f;
    logic [2:0]  ipl_n;
    logic        as_n = 1'b1;
    logic [2:0]  fc = 3'b000;
    logic [23:1] bus_addr = '0;
    logic [6:0]  iack_n;
    logic [7:0]  vec_out;
    logic        vec_oe;
    logic        dtack_n;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_lvl = '0;
    logic [7:0]  cfg_data = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference model state
    logic [6:0] m_s1, m_s2;
    int         m_vec [1:7];
    bit         m_oe;
    int         m_vout;
    bit         m_dt_n;
    bit         m_prev_oe;

    always #5 clk = ~clk;

    irq_glue i_irq_glue (
        .clk(clk), .rst(rst), .req_n(req_n), .ipl_n(ipl_n),
        .as_n(as_n), .fc(fc), .bus_addr(bus_addr), .iack_n(iack_n),
        .vec_out(vec_out), .vec_oe(vec_oe), .dtack_n(dtack_n),
        .cfg_we(cfg_we), .cfg_lvl(cfg_lvl), .cfg_data(cfg_data)
    );

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", rq, cycles, act, exp);
        end
    endtask

    function automatic int ack_level();
        if (!as_n && fc == 3'b111 && (&bus_addr[23:4])) return int'(bus_addr[3:1]);
        return 0;
    endfunction

    // model advance and comparison on every clock
    always @(posedge clk) begin
        int lv;
        int hi;
        int exp_iack;
        lv = ack_level();
        if (rst) begin
            m_s1 = 7'h7f; m_s2 = 7'h7f;
            for (int k = 1; k <= 7; k++) m_vec[k] = 8'h18 + k;
            m_oe = 0; m_vout = 0; m_dt_n = 1;
        end else begin
            m_prev_oe = m_oe;
            m_oe   = (lv != 0);
            m_vout = (lv != 0) ? m_vec[lv] : 0;
            m_dt_n = !((lv != 0) && m_prev_oe);
            if (cfg_we && cfg_lvl != 0) m_vec[cfg_lvl] = cfg_data;
            m_s2 = m_s1;
            m_s1 = req_n;
        end
        #2;
        if (!done) begin
            cycles++;
            hi = 0;
            for (int k = 0; k < 7; k++) if (!m_s2[k]) hi = k + 1;
            chk("R3 ipl_n", ipl_n, (~hi) & 7);
            lv = ack_level();
            exp_iack = 7'h7f;
            if (lv != 0) exp_iack = exp_iack & ~(1 << (lv - 1));
            chk("R5/R6 iack_n", iack_n, exp_iack);
            chk("R7 vec_oe", vec_oe, m_oe);
            chk("R7 vec_out", vec_out, m_vout);
            chk("R8/R9 dtack_n", dtack_n, m_dt_n);
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog: actual=running expected=finished");
                done = 1'b1;
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic ack_cycle(input int lvl, input logic [2:0] f, input bit hi_ok, input int len);
        @(negedge clk);
        fc       = f;
        bus_addr = {hi_ok ? 20'hfffff : 20'hffeff, 3'(lvl)};
        as_n     = 1'b0;
        ticks(len);
        as_n     = 1'b1;
        fc       = 3'b000;
        bus_addr = '0;
        ticks(2);
    endtask

    task automatic write_vec(input int lvl, input int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_lvl = 3'(lvl); cfg_data = 8'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        ticks(3);
        // R1: reset state of the outputs
        chk("R1 ipl_n reset", ipl_n, 7);
        chk("R1 vec_oe reset", vec_oe, 0);
        chk("R1 dtack_n reset", dtack_n, 1);
        rst = 1'b0;
        ticks(2);

        // R2 and R3: request patterns, including several at once
        req_n = 7'b1111110; ticks(4);
        req_n = 7'b1101010; ticks(4);
        req_n = 7'b0101111; ticks(4);
        req_n = 7'b1111111; ticks(1);
        req_n = 7'b1011111; ticks(1);
        req_n = 7'b1111111; ticks(4);
        // R2: single-cycle pulse still passes after two edges
        req_n = 7'b1110111; ticks(1);
        req_n = 7'b1111111; ticks(4);

        // R4, R5, R7, R8, R9: acknowledge each level, with the R1 default vectors
        for (int l = 0; l <= 7; l++) ack_cycle(l, 3'b111, 1'b1, 4);
        // R6: wrong function code, high address not all ones
        ack_cycle(3, 3'b110, 1'b1, 3);
        ack_cycle(5, 3'b111, 1'b0, 3);
        // R9: one-cycle strobe
        ack_cycle(6, 3'b111, 1'b1, 1);

        // R10: writes, including an ignored write to level 0
        write_vec(2, 8'ha5);
        write_vec(7, 8'h40);
        write_vec(0, 8'hee);
        for (int l = 1; l <= 7; l++) ack_cycle(l, 3'b111, 1'b1, 3);

        // requests during an acknowledge cycle
        req_n = 7'b0011100;
        ack_cycle(7, 3'b111, 1'b1, 5);
        req_n = 7'b1111111;
        ticks(4);

        // R1: reset restores the default vectors
        rst = 1'b1; ticks(2); rst = 1'b0;
        ack_cycle(2, 3'b111, 1'b1, 3);
        ack_cycle(7, 3'b111, 1'b1, 3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule